// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt sources into one raw level vector and drives two request lines toward a processor: a normal request and a fast request. Each request line has its own enable mask. Software changes a mask only by writing ones to a set word or to a clear word, so bits it does not name are never disturbed. Source 0 can also be raised from software through a latch that is ORed with hardware line 0. The block does no priority encoding, no vectoring and no edge detection.

Software reaches the block through a simple synchronous word port with separate write and read strobes and a word offset. Read data is registered. A system normally builds two copies: the normal-request output of a secondary controller drives hardware source 26 of the primary controller.

Top module: `intc_dual_out`

## Requirements
- R1: While `rst` is high at a clock edge, both enable masks, the software latch, the raw level vector, `irqOut`, `fiqOut` and `rdData` are cleared to zero.
- R2: A write to offset 2 ORs `wrData` into the normal enable mask. A read of offset 2 returns that mask.
- R3: A write to offset 3 clears the normal enable mask bits where `wrData` is one. Other bits keep their values.
- R4: Offsets 10 (set) and 11 (clear) act on the fast enable mask in the same way as R2 and R3. A read of offset 10 returns the fast mask. The two masks never affect each other.
- R5: At every clock edge, raw level bit i (i ≥ 1) takes the value of `srcIn[i]`. A read of offset 1 or offset 9 returns the raw level vector.
- R6: A read of offset 0 returns the raw level AND the normal mask. A read of offset 8 returns the raw level AND the fast mask.
- R7: `irqOut` is registered. After each edge it is high exactly when the raw level AND the normal mask was nonzero before that edge.
- R8: `fiqOut` follows the fast mask in the same way as R7.
- R9: A write to offset 4 with `wrData[0]`=1 sets the software latch. A write to offset 5 with `wrData[0]`=1 clears it. Other data bits of these writes have no effect. Raw level bit 0 takes `srcIn[0]` OR the latch at each edge, so it lags the latch by one edge.
- R10: A read of offset 4 returns raw level bit 0 in bit 0 and zeros in all other bits.
- R11: Writes to offsets 0, 1, 8 and 9, and to any unlisted offset, change no state. Reads of offsets 3, 5 and 11, and of any unlisted offset, return zero.
- R12: `rdData` loads the selected word at the edge where `rdEn` is high. It holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W (4) | Word offset |
| wrData | input | NUM_SRC (32) | Write data |
| rdData | output | NUM_SRC (32) | Registered read data |
| srcIn | input | NUM_SRC (32) | Level-sensitive source lines |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
A mask write takes effect at the edge where it is presented. A source line reaches the raw level at its sampling edge. The request outputs move one edge after either of these, so a mask write or a source change shows on `irqOut`/`fiqOut` two edges after it is driven. The software latch adds one more edge before it reaches level bit 0. Read data is due one edge after `rdEn`. The bench drives all inputs on falling edges. It advances a cycle-exact reference model at each rising edge, using values taken from the requirements. It compares the outputs and the read data on the next falling edge, so each result is sampled in exactly the cycle it is due.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // Word offsets of the software-visible registers
  localparam int unsigned OFS_IRQ_STAT   = 0;
  localparam int unsigned OFS_RAW_A      = 1;
  localparam int unsigned OFS_IRQ_EN_SET = 2;
  localparam int unsigned OFS_IRQ_EN_CLR = 3;
  localparam int unsigned OFS_SOFT_SET   = 4;
  localparam int unsigned OFS_SOFT_CLR   = 5;
  localparam int unsigned OFS_FIQ_STAT   = 8;
  localparam int unsigned OFS_RAW_B      = 9;
  localparam int unsigned OFS_FIQ_EN_SET = 10;
  localparam int unsigned OFS_FIQ_EN_CLR = 11;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_IRQ_STAT,
    RD_RAW,
    RD_IRQ_EN,
    RD_SOFT,
    RD_FIQ_STAT,
    RD_FIQ_EN
  } rdSel_e;

  typedef struct packed {
    logic   irqEnSet;
    logic   irqEnClr;
    logic   fiqEnSet;
    logic   fiqEnClr;
    logic   softSet;
    logic   softClr;
    logic   rdLoad;
    rdSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrBit0,
  output strobes_t          strb
);

  always_comb begin
    strb          = '0;
    strb.rdLoad   = rdEn;
    strb.rdSel    = RD_ZERO;
    // write decode: status and raw words are read-only, unlisted offsets ignored
    if (wrEn) begin
      case (addr)
        ADDR_W'(OFS_IRQ_EN_SET): strb.irqEnSet = 1'b1;
        ADDR_W'(OFS_IRQ_EN_CLR): strb.irqEnClr = 1'b1;
        ADDR_W'(OFS_FIQ_EN_SET): strb.fiqEnSet = 1'b1;
        ADDR_W'(OFS_FIQ_EN_CLR): strb.fiqEnClr = 1'b1;
        ADDR_W'(OFS_SOFT_SET):   strb.softSet  = wrBit0;
        ADDR_W'(OFS_SOFT_CLR):   strb.softClr  = wrBit0;
        default: ;
      endcase
    end
    // read decode: clear words and unlisted offsets read as zero
    case (addr)
      ADDR_W'(OFS_IRQ_STAT):   strb.rdSel = RD_IRQ_STAT;
      ADDR_W'(OFS_RAW_A):      strb.rdSel = RD_RAW;
      ADDR_W'(OFS_RAW_B):      strb.rdSel = RD_RAW;
      ADDR_W'(OFS_IRQ_EN_SET): strb.rdSel = RD_IRQ_EN;
      ADDR_W'(OFS_SOFT_SET):   strb.rdSel = RD_SOFT;
      ADDR_W'(OFS_FIQ_STAT):   strb.rdSel = RD_FIQ_STAT;
      ADDR_W'(OFS_FIQ_EN_SET): strb.rdSel = RD_FIQ_EN;
      default:                 strb.rdSel = RD_ZERO;
    endcase
  end

  // R11: at most one state-changing strobe per write
  assert_write_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.irqEnSet, strb.irqEnClr, strb.fiqEnSet,
              strb.fiqEnClr, strb.softSet, strb.softClr}));

  // R11: no write strobe without a write
  assert_no_strobe_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !wrEn |-> !(strb.irqEnSet | strb.irqEnClr | strb.fiqEnSet |
                strb.fiqEnClr | strb.softSet | strb.softClr));

endmodule

// File: rtl/intc_enable_mask.sv
module intc_enable_mask #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             setStb,
  input  logic             clrStb,
  input  logic [WIDTH-1:0] data,
  output logic [WIDTH-1:0] maskQ
);

  always_ff @(posedge clk) begin
    if (rst)         maskQ <= '0;
    else if (setStb) maskQ <= maskQ | data;
    else if (clrStb) maskQ <= maskQ & ~data;
  end

  // R2: every bit named by a set write is enabled afterwards
  assert_set_bits_R2: assert property (@(posedge clk) disable iff (rst)
    setStb |=> ((maskQ & $past(data)) == $past(data)));

  // R3: every bit named by a clear write is disabled afterwards
  assert_clr_bits_R3: assert property (@(posedge clk) disable iff (rst)
    (clrStb && !setStb) |=> ((maskQ & $past(data)) == '0));

  // R2/R3: the mask holds without a strobe
  assert_mask_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(setStb || clrStb) |=> $stable(maskQ));

endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  strobes_t           strb,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [NUM_SRC-1:0] rdData,
  output logic               irqOut,
  output logic               fiqOut
);

  logic [NUM_SRC-1:0] levelQ;
  logic [NUM_SRC-1:0] levelNext;
  logic [NUM_SRC-1:0] irqEnQ;
  logic [NUM_SRC-1:0] fiqEnQ;
  logic [NUM_SRC-1:0] rdNext;
  logic               softQ;

  intc_enable_mask #(.WIDTH(NUM_SRC)) uIrqMask (
    .clk(clk), .rst(rst), .setStb(strb.irqEnSet), .clrStb(strb.irqEnClr),
    .data(wrData), .maskQ(irqEnQ));

  intc_enable_mask #(.WIDTH(NUM_SRC)) uFiqMask (
    .clk(clk), .rst(rst), .setStb(strb.fiqEnSet), .clrStb(strb.fiqEnClr),
    .data(wrData), .maskQ(fiqEnQ));

  always_ff @(posedge clk) begin
    if (rst)               softQ <= 1'b0;
    else if (strb.softSet) softQ <= 1'b1;
    else if (strb.softClr) softQ <= 1'b0;
  end

  // level sampling; source 0 also carries the software latch
  for (genvar i = 0; i < NUM_SRC; i++) begin : gLevel
    if (i == 0) begin : gSoft
      assign levelNext[i] = srcIn[i] | softQ;
    end else begin : gHw
      assign levelNext[i] = srcIn[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      levelQ <= '0;
      irqOut <= 1'b0;
      fiqOut <= 1'b0;
    end else begin
      levelQ <= levelNext;
      irqOut <= |(levelQ & irqEnQ);
      fiqOut <= |(levelQ & fiqEnQ);
    end
  end

  always_comb begin
    case (strb.rdSel)
      RD_IRQ_STAT: rdNext = levelQ & irqEnQ;
      RD_RAW:      rdNext = levelQ;
      RD_IRQ_EN:   rdNext = irqEnQ;
      RD_SOFT:     rdNext = NUM_SRC'(levelQ[0]);
      RD_FIQ_STAT: rdNext = levelQ & fiqEnQ;
      RD_FIQ_EN:   rdNext = fiqEnQ;
      default:     rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)              rdData <= '0;
    else if (strb.rdLoad) rdData <= rdNext;
  end

  // R4: a fast-mask set leaves the normal mask untouched
  assert_fiq_isolated_R4: assert property (@(posedge clk) disable iff (rst)
    (strb.fiqEnSet || strb.fiqEnClr) |=> $stable(irqEnQ));

  // R7: no enabled pending source means the normal request drops next cycle
  assert_irq_low_R7: assert property (@(posedge clk) disable iff (rst)
    ((levelQ & irqEnQ) == '0) |=> !irqOut);

  // R8: an enabled pending source raises the fast request next cycle
  assert_fiq_high_R8: assert property (@(posedge clk) disable iff (rst)
    ((levelQ & fiqEnQ) != '0) |=> fiqOut);

  // R9: software set reaches level bit 0 two edges later
  assert_soft_reach_R9: assert property (@(posedge clk) disable iff (rst)
    softQ |=> levelQ[0]);

  // R9: soft set is seen in the latch one edge later
  assert_soft_set_R9: assert property (@(posedge clk) disable iff (rst)
    strb.softSet |=> softQ);

  // R12: read data holds without a read strobe
  assert_rd_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !strb.rdLoad |=> $stable(rdData));

endmodule

// File: rtl/intc_dual_out.sv
module intc_dual_out
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] wrData,
  output logic [NUM_SRC-1:0] rdData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irqOut,
  output logic               fiqOut
);

  strobes_t strb;

  intc_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrBit0(wrData[0]), .strb(strb));

  intc_datapath #(.NUM_SRC(NUM_SRC)) uDp (
    .clk(clk), .rst(rst), .strb(strb), .wrData(wrData), .srcIn(srcIn),
    .rdData(rdData), .irqOut(irqOut), .fiqOut(fiqOut));

endmodule

// File: tb/intc_dual_out_test.sv
`timescale 1ns/1ps
module intc_dual_out_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] srcIn = '0;
  logic [31:0] rdData;
  logic        irqOut, fiqOut;

  int checks = 0;
  int failures = 0;
  string rdTag = "R12";

  // reference model state
  logic        mSoft = 1'b0;
  logic [31:0] mLevel = '0, mIrqEn = '0, mFiqEn = '0, mRd = '0;
  logic        mIrq = 1'b0, mFiq = 1'b0;

  always #2 clk = ~clk;

  intc_dual_out uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .srcIn(srcIn),
    .irqOut(irqOut), .fiqOut(fiqOut));

  function automatic logic [31:0] readFn(input logic [3:0] a);
    case (a)
      4'd0:  return mLevel & mIrqEn;
      4'd1:  return mLevel;
      4'd9:  return mLevel;
      4'd2:  return mIrqEn;
      4'd4:  return {31'd0, mLevel[0]};
      4'd8:  return mLevel & mFiqEn;
      4'd10: return mFiqEn;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelEdge();
    logic        nSoft;
    logic [31:0] nIrqEn, nFiqEn, nRd;
    if (rst) begin
      mSoft = 0; mLevel = 0; mIrqEn = 0; mFiqEn = 0; mRd = 0; mIrq = 0; mFiq = 0;
      return;
    end
    nSoft = mSoft; nIrqEn = mIrqEn; nFiqEn = mFiqEn; nRd = mRd;
    if (wrEn) begin
      case (addr)
        4'd2:  nIrqEn = mIrqEn | wrData;
        4'd3:  nIrqEn = mIrqEn & ~wrData;
        4'd10: nFiqEn = mFiqEn | wrData;
        4'd11: nFiqEn = mFiqEn & ~wrData;
        4'd4:  if (wrData[0]) nSoft = 1'b1;
        4'd5:  if (wrData[0]) nSoft = 1'b0;
        default: ;
      endcase
    end
    if (rdEn) nRd = readFn(addr);
    mIrq = |(mLevel & mIrqEn);
    mFiq = |(mLevel & mFiqEn);
    mLevel = {srcIn[31:1], srcIn[0] | mSoft};
    mSoft = nSoft; mIrqEn = nIrqEn; mFiqEn = nFiqEn; mRd = nRd;
  endtask

  // one clock: inputs already driven; update model at edge, check at falling edge
  task automatic cycle();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    chk(rst ? "R1" : "R7", {31'd0, irqOut}, {31'd0, mIrq});
    chk(rst ? "R1" : "R8", {31'd0, fiqOut}, {31'd0, mFiq});
    chk(rst ? "R1" : (rdEn ? rdTag : "R12"), rdData, mRd);
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    cycle();
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    rdEn = 1'b1; addr = a; rdTag = tag;
    cycle();
    rdTag = "R12";
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    // R1: reset state
    repeat (3) cycle();
    rst = 1'b0;
    cycle();
    rd(4'd2, "R1"); chk("R1", rdData, 32'd0);
    rd(4'd10, "R1"); chk("R1", rdData, 32'd0);
    rd(4'd1, "R1"); chk("R1", rdData, 32'd0);

    // R5: raw level sampling
    srcIn = 32'h0000_00F0;
    cycle();
    rd(4'd1, "R5"); chk("R5", rdData, 32'h0000_00F0);
    rd(4'd9, "R5"); chk("R5", rdData, 32'h0000_00F0);

    // R2 / R7: normal enable set and request
    wr(4'd2, 32'h0000_0030);
    wr(4'd2, 32'h0000_0081);
    rd(4'd2, "R2"); chk("R2", rdData, 32'h0000_00B1);
    cycle();
    chk("R7", {31'd0, irqOut}, 32'd1);
    rd(4'd0, "R6"); chk("R6", rdData, 32'h0000_00B0);

    // R3: clear drops request two edges later
    wr(4'd3, 32'h0000_00F0);
    rd(4'd2, "R3"); chk("R3", rdData, 32'h0000_0001);
    cycle();
    chk("R7", {31'd0, irqOut}, 32'd0);

    // R4 / R8: fast mask on source 26 (cascade input)
    srcIn = 32'h0400_0000;
    wr(4'd10, 32'h0400_0000);
    cycle(); cycle();
    chk("R8", {31'd0, fiqOut}, 32'd1);
    chk("R4", {31'd0, irqOut}, 32'd0);
    rd(4'd8, "R6"); chk("R6", rdData, 32'h0400_0000);
    rd(4'd2, "R4"); chk("R4", rdData, 32'h0000_0001);
    wr(4'd11, 32'h0400_0000);
    rd(4'd10, "R4"); chk("R4", rdData, 32'd0);
    cycle();
    chk("R8", {31'd0, fiqOut}, 32'd0);

    // R9 / R10: software source
    wr(4'd4, 32'hFFFF_FFFE);
    cycle();
    rd(4'd4, "R9"); chk("R9", rdData, 32'd0);
    wr(4'd4, 32'h0000_0001);
    cycle();
    rd(4'd4, "R10"); chk("R10", rdData, 32'd1);
    cycle();
    chk("R9", {31'd0, irqOut}, 32'd1);
    wr(4'd5, 32'hFFFF_FFFE);
    cycle();
    rd(4'd4, "R9"); chk("R9", rdData, 32'd1);
    wr(4'd5, 32'h0000_0001);
    cycle();
    rd(4'd1, "R9"); chk("R9", rdData, 32'h0400_0000);

    // R11: read-only words ignore writes, clear words read zero
    wr(4'd0, 32'hFFFF_FFFF); wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd8, 32'hFFFF_FFFF); wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd7, 32'hFFFF_FFFF);
    rd(4'd2, "R11"); chk("R11", rdData, 32'h0000_0001);
    rd(4'd10, "R11"); chk("R11", rdData, 32'd0);
    wr(4'd2, 32'hFFFF_FFFF);
    rd(4'd3, "R11"); chk("R11", rdData, 32'd0);
    rd(4'd5, "R11"); chk("R11", rdData, 32'd0);
    rd(4'd11, "R11"); chk("R11", rdData, 32'd0);
    rd(4'd15, "R11"); chk("R11", rdData, 32'd0);

    // random phase against the model
    for (int n = 0; n < 4000; n++) begin
      int op;
      op = $urandom % 5;
      if (op == 0) srcIn = $urandom & $urandom & $urandom;
      if (op == 1 || op == 2) begin
        wrEn = 1'b1; addr = 4'($urandom); wrData = $urandom & $urandom;
      end else if (op == 3) begin
        rdEn = 1'b1; addr = 4'($urandom); rdTag = "R6";
      end
      cycle();
      rdTag = "R12";
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule